// File: doc/BRIEF.md
# Divider Chain and Square-Wave Selector

This block divides a 32.768 kHz oscillator clock through a 15-stage binary counter. It produces four timing signals for a real-time clock:
- a square-wave output;
- a one-cycle periodic strobe at a rate set by a 4-bit code;
- a one-cycle update strobe once per second;
- an update-busy status bit, which warns that an update is about to happen.

The calendar counters use the update strobe. An interrupt unit uses the periodic strobe. Software polls the busy bit before it reads the time.

Two control bits set the counter mode. With `osc_en_i` high and `chain_rst_i` low, the counter runs. With both high, the counter is held at zero. With `osc_en_i` low, the counter stops where it is. When the counter is released from the hold, the first update comes after half a second, and further updates come once per second. A freeze input suppresses updates while software sets the time.

The square-wave output has three sources, in priority order. A fast-override input passes the raw oscillator clock straight to the pin. Otherwise, the square-wave enable passes the selected tap. Otherwise, the pin is held low.

Top module: `sqw_divider`

## Requirements
- R1: While `rst_ni` is low, `sq_o` (with `fast_en_i` low), `tick_o`, `upd_o` and `busy_o` are all 0, and the counter is cleared to zero.
- R2: The counter mode depends on `osc_en_i` and `chain_rst_i` as follows. With `osc_en_i`=1 and `chain_rst_i`=0, the counter advances by one on every clock. With `osc_en_i`=1 and `chain_rst_i`=1, the counter is forced to zero, and on the next cycle `tick_o`, `upd_o` and `busy_o` are all 0.
- R3: The rate code sets the tap period P in clock cycles:
  - code 0 selects no tap, and the tap value is 0;
  - code 1 gives P=128 (256 Hz);
  - code 2 gives P=256 (128 Hz);
  - a code r from 3 to 15 gives P=2^(r-1), which runs from 8192 Hz down to 2 Hz.
  
  The tap is 1 exactly when (count mod P) is at least P/2.
- R4: `sq_o` is selected in this order:
  - when `fast_en_i`=1, `sq_o` equals `clk_i`, whatever the other controls are;
  - when `fast_en_i`=0 and `sq_en_i`=1, `sq_o` is the selected tap;
  - when both are 0, `sq_o` is 0.
- R5: `tick_o` pulses high for one cycle when the counter has just advanced and (count mod P) equals P/2. This is the first cycle of each high phase of the tap. The pulse does not depend on `sq_en_i`. It never fires for code 0, and it never fires in the same cycle as `upd_o`.
- R6: `upd_o` pulses high for one cycle when the counter has just advanced to a value where (count mod 32768) = 16384. The first pulse therefore comes 16384 cycles (half a second) after the counter leaves the hold, and later pulses come every 32768 cycles.
- R7: `busy_o` is 1 exactly while (count mod 32768) is in 16376..16384. This covers the 8 cycles before the update and the update cycle itself. `busy_o` falls on the cycle after `upd_o`.
- R8: While `freeze_i`=1, no update pulse is produced, and `busy_o` is 0 from the cycle after `freeze_i` is sampled high.
- R9: With `osc_en_i`=0, the counter holds its value even if `chain_rst_i`=1. No `tick_o` or `upd_o` is produced, and the tap output stays constant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | 32.768 kHz oscillator clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| osc_en_i | input | 1 | Oscillator run enable |
| chain_rst_i | input | 1 | Hold the counter at zero (only takes effect while `osc_en_i` is 1) |
| freeze_i | input | 1 | Suppress updates and clear busy |
| sq_en_i | input | 1 | Square-wave enable |
| fast_en_i | input | 1 | Pass the raw clock to `sq_o` |
| rate_i | input | 4 | Tap rate code |
| sq_o | output | 1 | Square-wave output |
| tick_o | output | 1 | Periodic strobe |
| upd_o | output | 1 | Once-per-second update strobe |
| busy_o | output | 1 | Update-busy status |

## Verification
All sixteen rate codes are swept from a freshly released counter. Each sweep checks the tap phase and the position of each strobe against the period computed for that code. This tells apart the two aliased low codes, the disabled code and the binary-spaced codes. Some codes run with the square-wave enable off, which separates the strobe path from the output gate.

Separate patterns cover the other controls:
- stopping the oscillator with and without the hold bit, which separates the stop mode from the hold mode;
- raising the fast override, sampled in both clock phases;
- a run of a second and a half, which places the half-second first update and the busy window;
- freezing the counter inside the busy window, which shows that the update is suppressed.

// File: rtl/sqw_pkg.sv
package sqw_pkg;
  // Counter bit carrying the tap for a rate code; -1 when the code selects nothing.
  function automatic int tap_bit(input int code);
    if (code == 0) return -1;
    if (code == 1) return 6;
    if (code == 2) return 7;
    return code - 2;
  endfunction
endpackage

// File: rtl/sqw_chain.sv
module sqw_chain #(
  parameter int STAGES = 15
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              osc_en_i,
  input  logic              chain_rst_i,
  output logic [STAGES-1:0] cnt_o,
  output logic              adv_o,
  output logic              hold_o
);
  logic [STAGES-1:0] cnt_q;

  assign adv_o  = osc_en_i & ~chain_rst_i;
  assign hold_o = osc_en_i & chain_rst_i;
  assign cnt_o  = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (hold_o) cnt_q <= '0;
    else if (adv_o)  cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/sqw_tap_sel.sv
module sqw_tap_sel #(
  parameter int STAGES = 15,
  parameter int RATE_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [STAGES-1:0] cnt_i,
  input  logic              adv_i,
  input  logic [RATE_W-1:0] rate_i,
  output logic              tap_o,
  output logic              tick_o
);
  localparam int NCODES = 2 ** RATE_W;

  logic [NCODES-1:0] tap_vec;
  logic [NCODES-1:0] rise_vec;
  logic              tick_q;

  assign tap_vec[0]  = 1'b0;
  assign rise_vec[0] = 1'b0;

  for (genvar r = 1; r < NCODES; r++) begin : g_tap
    localparam int K = sqw_pkg::tap_bit(r);
    assign tap_vec[r]  = cnt_i[K];
    // next increment raises bit K
    assign rise_vec[r] = ~cnt_i[K] & (&cnt_i[K-1:0]);
  end

  assign tap_o  = tap_vec[rate_i];
  assign tick_o = tick_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) tick_q <= 1'b0;
    else         tick_q <= adv_i & rise_vec[rate_i];
  end
endmodule

// File: rtl/sqw_update.sv
module sqw_update #(
  parameter int STAGES = 15,
  parameter int LEAD   = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [STAGES-1:0] cnt_i,
  input  logic              adv_i,
  input  logic              hold_i,
  input  logic              freeze_i,
  output logic              upd_o,
  output logic              busy_o
);
  localparam int HALF = 2 ** (STAGES - 1);
  localparam logic [STAGES-1:0] UPD_AT  = STAGES'(HALF - 1);
  localparam logic [STAGES-1:0] BUSY_AT = STAGES'(HALF - 1 - LEAD);

  logic upd_q, busy_q;

  assign upd_o  = upd_q;
  assign busy_o = busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      upd_q  <= 1'b0;
      busy_q <= 1'b0;
    end else begin
      upd_q <= adv_i & ~freeze_i & (cnt_i == UPD_AT);
      if (freeze_i || hold_i)              busy_q <= 1'b0;
      else if (adv_i && cnt_i == BUSY_AT)  busy_q <= 1'b1;
      else if (upd_q)                      busy_q <= 1'b0;
    end
  end
endmodule

// File: rtl/sqw_divider.sv
module sqw_divider #(
  parameter int STAGES = 15,
  parameter int RATE_W = 4,
  parameter int LEAD   = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              osc_en_i,
  input  logic              chain_rst_i,
  input  logic              freeze_i,
  input  logic              sq_en_i,
  input  logic              fast_en_i,
  input  logic [RATE_W-1:0] rate_i,
  output logic              sq_o,
  output logic              tick_o,
  output logic              upd_o,
  output logic              busy_o
);
  logic [STAGES-1:0] cnt;
  logic              adv, hold, tap;

  sqw_chain #(.STAGES(STAGES)) u_chain (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .osc_en_i    (osc_en_i),
    .chain_rst_i (chain_rst_i),
    .cnt_o       (cnt),
    .adv_o       (adv),
    .hold_o      (hold)
  );

  sqw_tap_sel #(.STAGES(STAGES), .RATE_W(RATE_W)) u_tap (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .cnt_i  (cnt),
    .adv_i  (adv),
    .rate_i (rate_i),
    .tap_o  (tap),
    .tick_o (tick_o)
  );

  sqw_update #(.STAGES(STAGES), .LEAD(LEAD)) u_upd (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .cnt_i    (cnt),
    .adv_i    (adv),
    .hold_i   (hold),
    .freeze_i (freeze_i),
    .upd_o    (upd_o),
    .busy_o   (busy_o)
  );

  // override passes the oscillator straight through
  assign sq_o = fast_en_i ? clk_i : (sq_en_i & tap);
endmodule

// File: rtl/sqw_divider_chk.sv
module sqw_divider_chk #(
  parameter int RATE_W = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              osc_en_i,
  input logic              chain_rst_i,
  input logic              freeze_i,
  input logic              sq_en_i,
  input logic              fast_en_i,
  input logic [RATE_W-1:0] rate_i,
  input logic              sq_o,
  input logic              tick_o,
  input logic              upd_o,
  input logic              busy_o
);
  p_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (osc_en_i && chain_rst_i) |=> (!tick_o && !upd_o && !busy_o));

  p_code0_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rate_i == '0 && !fast_en_i) |-> !sq_o);

  p_sq_low_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!fast_en_i && !sq_en_i) |-> !sq_o);

  p_excl_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(tick_o && upd_o));

  p_upd_pulse_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_o |=> !upd_o);

  p_busy_fall_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_o |=> !busy_o);

  p_freeze_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    freeze_i |=> (!upd_o && !busy_o));

  p_off_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !osc_en_i |=> (!tick_o && !upd_o));
endmodule

bind sqw_divider sqw_divider_chk #(.RATE_W(RATE_W)) u_chk (.*);

// File: tb/sqw_divider_bench.sv
module sqw_divider_bench;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       osc, crst, frz, sq_en, fast;
  logic [3:0] rate;
  logic       sq, tick, upd, busy;

  int  checks = 0;
  int  errors = 0;
  bit  chk_busy = 1;
  bit  done = 0;
  int  upd_seen = 0;

  logic [14:0] m;
  logic        padv, pfrz;

  always #2.5 clk = ~clk;

  sqw_divider u_sqw_divider (
    .clk_i(clk), .rst_ni(rst_n), .osc_en_i(osc), .chain_rst_i(crst),
    .freeze_i(frz), .sq_en_i(sq_en), .fast_en_i(fast), .rate_i(rate),
    .sq_o(sq), .tick_o(tick), .upd_o(upd), .busy_o(busy)
  );

  // reference count from the mode rules of R2 and R9
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m <= '0; padv <= 1'b0; pfrz <= 1'b0;
    end else begin
      padv <= osc & ~crst;
      pfrz <= frz;
      if (osc && crst) m <= '0;
      else if (osc)    m <= m + 1'b1;
    end
  end

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b (count %0d, rate %0d)", req, act, exp, m, rate);
    end
  endtask

  function automatic int period(input int r);
    if (r == 1) return 128;
    if (r == 2) return 256;
    return 1 << (r - 1);
  endfunction

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      begin
        int p, ph, sec;
        logic e_tap, e_tick, e_upd, e_busy;
        sec = int'(m);
        if (rate == 0) begin
          e_tap = 1'b0; e_tick = 1'b0;
        end else begin
          p = period(int'(rate));
          ph = sec % p;
          e_tap  = (ph >= p / 2);
          e_tick = padv && (ph == p / 2);
        end
        e_upd  = padv && !pfrz && (sec % 32768 == 16384);
        e_busy = (sec % 32768 >= 16376) && (sec % 32768 <= 16384);
        chk("R3/R4 sq", sq, fast ? 1'b0 : (sq_en & e_tap));
        chk("R5 tick", tick, e_tick);
        chk("R6 upd", upd, e_upd);
        if (chk_busy) chk("R7 busy", busy, e_busy);
        if (upd) upd_seen++;
      end
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(5.0 * 190000);
    errors++;
    $display("FAIL watchdog: actual hung expected finished");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; osc = 1'b1; crst = 1'b0; frz = 1'b0;
    sq_en = 1'b1; fast = 1'b0; rate = 4'd3;
    repeat (4) @(negedge clk);
    chk("R1 sq", sq, 1'b0);
    chk("R1 tick", tick, 1'b0);
    chk("R1 upd", upd, 1'b0);
    chk("R1 busy", busy, 1'b0);
    rst_n = 1'b1;
    step(1);

    // R3 R5 sweep of every rate code from a fresh release
    for (int r = 0; r < 16; r++) begin
      rate = 4'(r); sq_en = (r % 3 != 0); crst = 1'b1;
      step(2);
      chk("R2 hold sq", sq, 1'b0);
      crst = 1'b0;
      step(600);
    end

    // R9 stop mode, with and without the hold bit
    rate = 4'd4; sq_en = 1'b1;
    step(13);
    osc = 1'b0;
    step(40);
    crst = 1'b1;
    step(20);
    chk("R9 tick", tick, 1'b0);
    crst = 1'b0; osc = 1'b1;
    step(30);

    // R4 override, both clock phases
    rate = 4'd5; sq_en = 1'b0; fast = 1'b1;
    for (int i = 0; i < 6; i++) begin
      @(posedge clk); #1;
      chk("R4 fast high", sq, 1'b1);
      step(1);
    end
    fast = 1'b0;
    step(4);

    // R6 R7 half second then one second
    rate = 4'd15; sq_en = 1'b1; crst = 1'b1;
    step(2);
    crst = 1'b0; upd_seen = 0;
    step(16384 + 32768 + 40);
    checks++;
    if (upd_seen != 2) begin
      errors++;
      $display("FAIL R6 update count: actual %0d expected 2", upd_seen);
    end

    // R8 freeze inside the busy window
    crst = 1'b1;
    step(2);
    crst = 1'b0;
    step(16378);
    chk("R7 busy window", busy, 1'b1);
    chk_busy = 0; frz = 1'b1;
    for (int i = 0; i < 20; i++) begin
      step(1);
      chk("R8 busy frozen", busy, 1'b0);
      chk("R8 no update", upd, 1'b0);
    end
    frz = 1'b0;
    step(5);
    chk("R8 busy after", busy, 1'b0);
    finish_run();
  end
endmodule